// File: doc/BRIEF.md
# Bit Manipulation and Rotate Unit

This unit executes the bit-level instruction group of a small 8-bit processor core: rotates (with and without the carry flag), arithmetic and logical shifts, nibble swap, single-bit test, single-bit clear and single-bit set. Instruction decode and operand fetch sit outside it. The decoder presents the operand, a 3-bit bit index, the current carry flag, a 4-bit operation code and a marker for the short accumulator rotate forms. One clock later the unit returns the result byte, the four condition flags, a write-enable for the result and a per-flag update mask.

The arithmetic itself is combinational. A single register stage captures the result and flags so that the block drops into a pipelined datapath at a fixed one-cycle latency. Any flag whose mask bit is clear reads 0, so the consumer can merge the flags with a plain masked write.

Top module: `bitu_core`

## Requirements
- R1: While `rst_n` is low, all outputs are 0, including `wr_en_o` and `fmask_o`.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.
- R3: Op 2 rotates left through carry: result = {a[6:0], cin}, C = a[7]. Op 3 rotates right through carry: result = {cin, a[7:1]}, C = a[0].
- R4: Op 0 rotates left: result = {a[6:0], a[7]}, C = a[7]. Op 1 rotates right: result = {a[0], a[7:1]}, C = a[0].
- R5: Op 4 shifts left and fills with 0, C = a[7]. Op 5 shifts right and keeps bit 7, C = a[0]. Op 6 shifts right and fills with 0, C = a[0].
- R6: Ops 0 to 6 set Z when the result is 0, clear N and H, assert `wr_en_o` and drive `fmask_o` = 4'b1111. Mask bit 3 is Z, bit 2 is N, bit 1 is H and bit 0 is C.
- R7: When `short_i` is 1 and the op is 0 to 3, Z is 0 whatever the result. For every other op `short_i` has no effect.
- R8: Op 7 exchanges the upper and lower nibbles, sets Z from the result, clears N, H and C, asserts `wr_en_o` and drives `fmask_o` = 4'b1111.
- R9: Op 8 tests bit `idx_i` of the operand: Z = 1 when that bit is 0, N = 0, H = 1, `fmask_o` = 4'b1110, `wr_en_o` = 0, and the result equals the operand.
- R10: Op 9 clears bit `idx_i` and op 10 sets bit `idx_i`, where index 0 is the least significant bit. Both assert `wr_en_o` and drive `fmask_o` = 4'b0000.
- R11: Op codes 11 to 15 return the operand unchanged with `wr_en_o` = 0, `fmask_o` = 0 and all flags 0.
- R12: Every flag output whose mask bit is 0 reads 0. This includes C on op 8 and all four flags on ops 9 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_i | input | 8 | Operand byte |
| idx_i | input | 3 | Bit index for test, clear and set |
| cin_i | input | 1 | Incoming carry flag |
| op_i | input | 4 | Operation code |
| short_i | input | 1 | Marks the short accumulator rotate form |
| res_o | output | 8 | Result byte |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Subtract flag |
| h_o | output | 1 | Half-carry flag |
| c_o | output | 1 | Carry flag |
| wr_en_o | output | 1 | Result must be written back |
| fmask_o | output | 4 | Flag update mask {Z,N,H,C} |

## Verification
The unit holds no state beyond its output register. A wrong internal value therefore shows at the ports on the very next cycle as a wrong result byte, a wrong flag or a wrong mask for that single input, and it never carries over into later operations. A bad bit-index decode corrupts only the patterns that use that index. For this reason the bench drives every operand value with both carry values for every op code, and every index for the bit ops, so each decoder line and each shift path is exercised against every data pattern.

// File: rtl/bitu_pkg.sv
package bitu_pkg;

    localparam int DW   = 8;
    localparam int IDXW = $clog2(DW);
    localparam int OPW  = 4;
    localparam int FW   = 4;

    typedef enum logic [OPW-1:0] {
        OP_ROL  = 4'd0,
        OP_ROR  = 4'd1,
        OP_RCL  = 4'd2,
        OP_RCR  = 4'd3,
        OP_SHL  = 4'd4,
        OP_ASR  = 4'd5,
        OP_LSR  = 4'd6,
        OP_SWAP = 4'd7,
        OP_TST  = 4'd8,
        OP_CLR  = 4'd9,
        OP_SETB = 4'd10
    } op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          z;
        logic          n;
        logic          h;
        logic          c;
        logic          wr;
        logic [FW-1:0] mask;
    } out_t;

endpackage

// File: rtl/bitu_mask_dec.sv
module bitu_mask_dec #(
    parameter int W    = 8,
    parameter int IDXW = $clog2(W)
) (
    input  logic [IDXW-1:0] idx,
    output logic [W-1:0]    mask
);

    for (genvar i = 0; i < W; i++) begin : g_line
        assign mask[i] = (idx == IDXW'(i));
    end

    always_comb begin
        a_r10_mask_onehot: assert ($countones(mask) == 1)
            else $error("index decode is not one-hot");
    end

endmodule

// File: rtl/bitu_shift.sv
module bitu_shift
    import bitu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  op_e          op,
    output logic [W-1:0] y,
    output logic         cout
);

    always_comb begin
        y    = a;
        cout = 1'b0;
        case (op)
            OP_ROL: begin y = {a[W-2:0], a[W-1]}; cout = a[W-1]; end
            OP_ROR: begin y = {a[0], a[W-1:1]};   cout = a[0];   end
            OP_RCL: begin y = {a[W-2:0], cin};    cout = a[W-1]; end
            OP_RCR: begin y = {cin, a[W-1:1]};    cout = a[0];   end
            OP_SHL: begin y = {a[W-2:0], 1'b0};   cout = a[W-1]; end
            OP_ASR: begin y = {a[W-1], a[W-1:1]}; cout = a[0];   end
            OP_LSR: begin y = {1'b0, a[W-1:1]};   cout = a[0];   end
            default: ;
        endcase
    end

endmodule

// File: rtl/bitu_bitop.sv
module bitu_bitop
    import bitu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  op_e          op,
    output logic [W-1:0] y,
    output logic         sel_zero
);

    localparam int HW = W / 2;

    assign sel_zero = ~|(a & m);

    always_comb begin
        case (op)
            OP_CLR:  y = a & ~m;
            OP_SETB: y = a | m;
            OP_SWAP: y = {a[HW-1:0], a[W-1:HW]};
            default: y = a;
        endcase
    end

endmodule

// File: rtl/bitu_core.sv
module bitu_core
    import bitu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   opnd_i,
    input  logic [IDXW-1:0] idx_i,
    input  logic            cin_i,
    input  logic [OPW-1:0]  op_i,
    input  logic            short_i,
    output logic [DW-1:0]   res_o,
    output logic            z_o,
    output logic            n_o,
    output logic            h_o,
    output logic            c_o,
    output logic            wr_en_o,
    output logic [FW-1:0]   fmask_o
);

    localparam logic [FW-1:0] MASK_ALL = {FW{1'b1}};
    localparam logic [FW-1:0] MASK_TST = 4'b1110;

    op_e            op;
    logic [DW-1:0]  bit_mask;
    logic [DW-1:0]  sh_y;
    logic           sh_c;
    logic [DW-1:0]  bo_y;
    logic           bo_zero;
    logic           is_rot;
    out_t           out_d;
    out_t           out_q;

    assign op     = op_e'(op_i);
    assign is_rot = (op_i < OPW'(4));

    bitu_mask_dec #(.W(DW), .IDXW(IDXW)) u_dec (
        .idx  (idx_i),
        .mask (bit_mask)
    );

    bitu_shift #(.W(DW)) u_shift (
        .a    (opnd_i),
        .cin  (cin_i),
        .op   (op),
        .y    (sh_y),
        .cout (sh_c)
    );

    bitu_bitop #(.W(DW)) u_bitop (
        .a        (opnd_i),
        .m        (bit_mask),
        .op       (op),
        .y        (bo_y),
        .sel_zero (bo_zero)
    );

    always_comb begin
        out_d     = '0;
        out_d.res = opnd_i;
        case (op)
            OP_ROL, OP_ROR, OP_RCL, OP_RCR, OP_SHL, OP_ASR, OP_LSR: begin
                out_d.res  = sh_y;
                out_d.z    = (short_i && is_rot) ? 1'b0 : ~|sh_y;
                out_d.c    = sh_c;
                out_d.wr   = 1'b1;
                out_d.mask = MASK_ALL;
            end
            OP_SWAP: begin
                out_d.res  = bo_y;
                out_d.z    = ~|bo_y;
                out_d.wr   = 1'b1;
                out_d.mask = MASK_ALL;
            end
            OP_TST: begin
                out_d.z    = bo_zero;
                out_d.h    = 1'b1;
                out_d.mask = MASK_TST;
            end
            OP_CLR, OP_SETB: begin
                out_d.res = bo_y;
                out_d.wr  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o   = out_q.res;
    assign z_o     = out_q.z;
    assign n_o     = out_q.n;
    assign h_o     = out_q.h;
    assign c_o     = out_q.c;
    assign wr_en_o = out_q.wr;
    assign fmask_o = out_q.mask;

    a_r9_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd8) |-> (!wr_en_o && h_o && !n_o))
        else $error("bit test wrote a result");

    a_r10_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd9) |-> (res_o[$past(idx_i)] == 1'b0 && fmask_o == '0))
        else $error("bit clear failed");

    a_r10_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd10) |-> (res_o[$past(idx_i)] == 1'b1 && fmask_o == '0))
        else $error("bit set failed");

    a_r7_short_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(short_i) && $past(op_i) < 4'd4) |-> !z_o)
        else $error("short rotate produced Z");

    a_r8_swap_nibbles: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd7) |-> (res_o == {$past(opnd_i[3:0]), $past(opnd_i[7:4])} && !c_o))
        else $error("swap mismatch");

    a_r12_unmasked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({z_o & ~fmask_o[3], n_o & ~fmask_o[2], h_o & ~fmask_o[1], c_o & ~fmask_o[0]}) == 0))
        else $error("unmasked flag nonzero");

endmodule

// File: tb/sim_bitu_core.sv
module sim_bitu_core;

    typedef struct {
        logic [16:0] exp;
        string       tag;
        int          op;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd_i = '0;
    logic [2:0] idx_i = '0;
    logic       cin_i = 1'b0;
    logic [3:0] op_i = '0;
    logic       short_i = 1'b0;
    logic [7:0] res_o;
    logic       z_o, n_o, h_o, c_o, wr_en_o;
    logic [3:0] fmask_o;

    int checks = 0;
    int failures = 0;
    item_t sb[$];

    always #5 clk = ~clk;

    bitu_core u0 (
        .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .idx_i(idx_i),
        .cin_i(cin_i), .op_i(op_i), .short_i(short_i),
        .res_o(res_o), .z_o(z_o), .n_o(n_o), .h_o(h_o), .c_o(c_o),
        .wr_en_o(wr_en_o), .fmask_o(fmask_o)
    );

    function automatic logic [16:0] model(input int op, input logic [7:0] a,
                                          input int idx, input logic cin, input logic sh);
        logic [7:0] r;
        logic z, n, h, c, w;
        logic [3:0] m;
        r = a; z = 0; n = 0; h = 0; c = 0; w = 0; m = 4'b0000;
        if (op <= 6) begin
            for (int i = 0; i < 8; i++) begin
                case (op)
                    0: r[i] = a[(i + 7) % 8];
                    1: r[i] = a[(i + 1) % 8];
                    2: r[i] = (i == 0) ? cin : a[i-1];
                    3: r[i] = (i == 7) ? cin : a[i+1];
                    4: r[i] = (i == 0) ? 1'b0 : a[i-1];
                    5: r[i] = (i == 7) ? a[7] : a[i+1];
                    default: r[i] = (i == 7) ? 1'b0 : a[i+1];
                endcase
            end
            c = (op == 0 || op == 2 || op == 4) ? a[7] : a[0];
            z = (sh && op <= 3) ? 1'b0 : (r == 8'h00);
            w = 1; m = 4'b1111;
        end else if (op == 7) begin
            r = {a[3:0], a[7:4]};
            z = (r == 8'h00); w = 1; m = 4'b1111;
        end else if (op == 8) begin
            z = (a[idx] == 1'b0); h = 1; m = 4'b1110;
        end else if (op == 9 || op == 10) begin
            r[idx] = (op == 10);
            w = 1;
        end
        return {r, z, n, h, c, w, m};
    endfunction

    function automatic string tag_of(input int op, input logic sh);
        if (sh && op > 3) return "R7";
        if (sh) return "R7 R6";
        case (op)
            0, 1: return "R4 R6";
            2, 3: return "R3 R6";
            4, 5, 6: return "R5 R6";
            7: return "R8";
            8: return "R9 R12";
            9, 10: return "R10 R12";
            default: return "R11";
        endcase
    endfunction

    task automatic drive(input int op, input logic [7:0] a, input int idx,
                         input logic cin, input logic sh);
        item_t it;
        @(negedge clk);
        op_i = 4'(op); opnd_i = a; idx_i = 3'(idx); cin_i = cin; short_i = sh;
        it.exp = model(op, a, idx, cin, sh);
        it.tag = tag_of(op, sh);
        it.op  = op;
        sb.push_back(it);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            logic [16:0] got;
            it  = sb.pop_front();
            got = {res_o, z_o, n_o, h_o, c_o, wr_en_o, fmask_o};
            checks++;
            if (got !== it.exp) begin
                failures++;
                $display("FAIL %s (R2 one-cycle) op=%0d got=%h exp=%h", it.tag, it.op, got, it.exp);
            end
        end
    end

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        // R1: reset state with active-looking inputs
        op_i = 4'd10; opnd_i = 8'hFF; cin_i = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if ({res_o, z_o, n_o, h_o, c_o, wr_en_o, fmask_o} !== 17'h0) begin
            failures++;
            $display("FAIL R1 reset got=%h exp=0", {res_o, z_o, n_o, h_o, c_o, wr_en_o, fmask_o});
        end
        rst_n = 1'b1;
        // directed corner cases
        drive(2, 8'h80, 0, 1'b0, 1'b0);   // R3 result zero, C set
        drive(3, 8'h01, 0, 1'b0, 1'b0);   // R3
        drive(0, 8'h00, 0, 1'b1, 1'b1);   // R7 zero result but Z forced 0
        drive(7, 8'h00, 0, 1'b1, 1'b1);   // R7 ignored on swap
        drive(5, 8'h81, 0, 1'b0, 1'b0);   // R5 sign kept
        drive(8, 8'hFE, 0, 1'b1, 1'b0);   // R9 bit 0 clear, C not reported
        drive(9, 8'hFF, 0, 1'b1, 1'b0);   // R10 index 0 is LSB
        drive(10, 8'h00, 7, 1'b1, 1'b0);  // R10 index 7 is MSB
        drive(13, 8'h5A, 3, 1'b1, 1'b1);  // R11
        // exhaustive sweep
        for (int op = 0; op < 16; op++) begin
            for (int s = 0; s < 2; s++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    for (int v = 0; v < 256; v++) begin
                        if (op >= 8 && op <= 10) begin
                            for (int ix = 0; ix < 8; ix++)
                                drive(op, 8'(v), ix, 1'(ci), 1'(s));
                        end else begin
                            drive(op, 8'(v), (v ^ 3) & 7, 1'(ci), 1'(s));
                        end
                    end
                end
            end
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule